// File: doc/BRIEF.md
# Sequenced Replay Buffer with Timeout Recovery

This block sits in the transmit path of a link layer and makes delivery reliable. Each packet accepted on the input stream gets the next 8-bit sequence number, wrapping from 255 to 0. A copy is kept in a slot of a small store, and the packet is offered on the output stream tagged with its number. The far end returns a positive acknowledgement naming a sequence number only for packets that arrived intact. Such an acknowledgement is cumulative: it releases the named packet and every older one still held.

There is no negative acknowledgement. When packets are outstanding and no releasing acknowledgement arrives for a fixed number of cycles, the block rewinds. It sends again every held packet from the oldest unacknowledged one onward, in the original order, with the original numbers and contents. It refuses new input until that rewind has been sent completely. Error coding and framing belong to neighbouring blocks.

Top module: `seq_replay_buf`

## Requirements
- R1: After reset, out_valid and out_replay are 0 and in_ready is 1. The first packet accepted after reset carries sequence number 0.
- R2: Each accepted packet is offered once on the output with unchanged data. Its out_seq is one more (mod 256) than that of the previously accepted packet.
- R3: While DEPTH packets are unacknowledged, in_ready is 0 and in_valid is ignored. A refused packet never appears on the output and takes no sequence number.
- R4: An acknowledgement with identifier N, where N lies in the held window, releases N and every older held packet. The released slots can then be refilled.
- R5: An acknowledgement whose identifier is not one of the held packets (already released, or never assigned) releases nothing.
- R6: A replay starts exactly TIMEOUT cycles after the timer's last restart, provided packets are still held. The timer stays cleared while nothing is held and while a replay is running. Its cycle count begins once at least one packet is held.
- R7: A replay resends every held packet from the oldest unacknowledged one through the newest, in order, with original sequence numbers and data, and with out_replay at 1.
- R8: in_ready is 0 from the start of a replay until its last packet has been sent. After that, input is accepted again.
- R9: Each acknowledgement that releases at least one packet restarts the timer, so the next replay comes TIMEOUT cycles after that acknowledgement.
- R10: With no packet held, no replay ever starts.
- R11: An acknowledgement that arrives during a replay releases packets that are still waiting to be resent. Those packets are skipped, and the replay continues from the oldest packet still held.
- R12: Sequence numbers wrap from 255 to 0. An acknowledgement whose identifier is past the wrap releases held packets numbered before the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | New packet offered |
| in_data | input | DATA_W | New packet payload |
| in_ready | output | 1 | New packet accepted this cycle when in_valid is 1 |
| out_valid | output | 1 | Packet offered downstream |
| out_data | output | DATA_W | Payload of the offered packet |
| out_seq | output | 8 | Sequence number of the offered packet |
| out_replay | output | 1 | A replay is in progress; the offered packet is a resend |
| out_ready | input | 1 | Downstream takes the offered packet this cycle |
| ack_valid | input | 1 | Acknowledgement present |
| ack_seq | input | 8 | Identifier of the newest packet acknowledged |

## Verification
The assertions rely on a few things about the inputs. The window test means an acknowledgement never names a packet older than the held window as if it were new. DEPTH is a power of two no larger than 128, so the 8-bit window cannot alias. TIMEOUT is at least 2. The bench acknowledges only numbers it has itself seen leave the output. Its one out-of-window identifier is a number it has already released, which makes the R5 case deliberate. In every scenario it spaces its acknowledgements well inside TIMEOUT, except where a timeout is the intended outcome.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
// rb_pkg: shared sequence-number type and modular distance helper for the
// replay buffer. Assumes sequence numbers are SEQ_W bits and wrap freely.
package rb_pkg;
    localparam int SEQ_W = 8;
    typedef logic [SEQ_W-1:0] seq_t;

    // Forward distance from 'from' to 'to' modulo 2**SEQ_W.
    function automatic seq_t seq_dist(seq_t from, seq_t to);
        return seq_t'(to - from);
    endfunction
endpackage

// File: rtl/rb_store.sv
`timescale 1ns/1ps
// rb_store: packet copy storage, one register slot per buffer entry, one
// write port and one asynchronous read port. Assumes DEPTH is a power of two
// and that the caller never writes a slot that still holds a live packet.
module rb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_bus [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            logic [DATA_W-1:0] q;
            // Capture the payload when this slot is the write target.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    q <= wr_data;
                end
            end
            assign slot_bus[g] = q;
        end
    endgenerate

    // Present the slot selected by the read index.
    always_comb begin
        rd_data = slot_bus[rd_idx];
    end
endmodule

// File: rtl/rb_timer.sv
`timescale 1ns/1ps
// rb_timer: acknowledgement timeout counter. It counts while 'run' is high,
// is cleared by 'restart', by 'run' low, and by its own expiry. 'expired'
// pulses for one cycle once TIMEOUT cycles have elapsed since the counter
// last sat at zero. Assumes TIMEOUT >= 2.
module rb_timer #(
    parameter int TIMEOUT = 64,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    // Expiry is the cycle in which the counter has reached its last value.
    always_comb begin
        expired = run && !restart && (cnt_q == LAST);
    end

    // Advance, clear or hold the elapsed-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/rb_ack_dec.sv
`timescale 1ns/1ps
// rb_ack_dec: judges an incoming acknowledgement against the held window
// [head, tail) and, when it releases entries, gives the new oldest-held
// number. Assumes the window never exceeds half the sequence space.
module rb_ack_dec
    import rb_pkg::*;
(
    input  seq_t head,
    input  seq_t tail,
    input  logic ack_valid,
    input  seq_t ack_id,
    output logic hit,
    output seq_t head_nx
);
    seq_t held;
    seq_t ack_off;

    // Release only when the named packet is one of those still held.
    always_comb begin
        held    = seq_dist(head, tail);
        ack_off = seq_dist(head, ack_id);
        hit     = ack_valid && (ack_off < held);
        head_nx = seq_t'(ack_id + 1'b1);
    end
endmodule

// File: rtl/seq_replay_buf.sv
`timescale 1ns/1ps
// seq_replay_buf: numbers outgoing packets, holds a copy of each until it
// is acknowledged cumulatively, and on an acknowledgement timeout resends
// the whole unacknowledged tail in order. The slot of a packet is the low
// bits of its sequence number. Assumes DEPTH is a power of two, at most
// 128, and TIMEOUT >= 2.
module seq_replay_buf
    import rb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [7:0]        out_seq,
    output logic              out_replay,
    input  logic              out_ready,
    input  logic              ack_valid,
    input  logic [7:0]        ack_seq
);
    localparam int   IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam seq_t DEPTH_S = seq_t'(DEPTH);

    seq_t head_q, tail_q, send_q;
    seq_t head_n, tail_n, send_n;
    logic replay_q, replay_n;
    seq_t held;
    logic full, push, sent;
    logic ack_hit;
    seq_t ack_head;
    logic timeout;
    logic tmr_run;
    seq_t step_s;

    // Occupancy and stream handshakes.
    always_comb begin
        held      = seq_dist(head_q, tail_q);
        full      = (held == DEPTH_S);
        in_ready  = !full && !replay_q;
        push      = in_valid && in_ready;
        out_valid = (send_q != tail_q);
        out_seq   = send_q;
        out_replay = replay_q;
        sent      = out_valid && out_ready;
        tmr_run   = (held != '0) && !replay_q;
    end

    rb_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_idx  (tail_q[IDX_W-1:0]),
        .wr_data (in_data),
        .rd_idx  (send_q[IDX_W-1:0]),
        .rd_data (out_data)
    );

    rb_ack_dec ack_i (
        .head      (head_q),
        .tail      (tail_q),
        .ack_valid (ack_valid),
        .ack_id    (ack_seq),
        .hit       (ack_hit),
        .head_nx   (ack_head)
    );

    rb_timer #(
        .TIMEOUT (TIMEOUT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (ack_hit),
        .expired (timeout)
    );

    // Next pointers: release on ack, grow on push, advance or rewind sender.
    always_comb begin
        head_n = ack_hit ? ack_head : head_q;
        tail_n = push ? seq_t'(tail_q + 1'b1) : tail_q;
        step_s = sent ? seq_t'(send_q + 1'b1) : send_q;
        if (timeout) begin
            send_n = head_q;
        end else if (ack_hit && (seq_dist(head_q, step_s) < seq_dist(head_q, head_n))) begin
            send_n = head_n;
        end else begin
            send_n = step_s;
        end
        if (timeout) begin
            replay_n = 1'b1;
        end else if (replay_q && (send_n == tail_n)) begin
            replay_n = 1'b0;
        end else begin
            replay_n = replay_q;
        end
    end

    // Register the window pointers and the replay flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            send_q   <= '0;
            replay_q <= 1'b0;
        end else begin
            head_q   <= head_n;
            tail_q   <= tail_n;
            send_q   <= send_n;
            replay_q <= replay_n;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        held <= DEPTH_S); // R3
    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (held == DEPTH_S) |=> $stable(tail_q)); // R3
    AST_SEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        seq_dist(head_q, send_q) <= held); // R7
    AST_REPLAY_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(replay_q) |-> (send_q == head_q)); // R7
    AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        replay_q |=> $stable(tail_q)); // R8
    AST_NO_EMPTY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        ((held == '0) && !replay_q) |=> !replay_q); // R10
endmodule

// File: tb/seq_replay_buf_tb.sv
`timescale 1ns/1ps
module seq_replay_buf_tb_top;
    localparam int DATA_W  = 16;
    localparam int DEPTH   = 8;
    localparam int TIMEOUT = 64;
    localparam int LOGN    = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [7:0]        out_seq;
    logic              out_replay;
    logic              out_ready = 1'b1;
    logic              ack_valid = 1'b0;
    logic [7:0]        ack_seq = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_tail = 0;
    bit done = 1'b0;

    logic [7:0]        lg_seq [LOGN];
    logic [DATA_W-1:0] lg_dat [LOGN];
    logic              lg_rep [LOGN];
    int lg_n = 0;
    int lg_rd = 0;

    always #2.5 clk = ~clk;

    seq_replay_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_seq(out_seq),
        .out_replay(out_replay), .out_ready(out_ready),
        .ack_valid(ack_valid), .ack_seq(ack_seq)
    );

    // Record every transfer on the output, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && lg_n < LOGN) begin
            lg_seq[lg_n] = out_seq;
            lg_dat[lg_n] = out_data;
            lg_rep[lg_n] = out_replay;
            lg_n++;
        end
    end

    function automatic logic [DATA_W-1:0] pat(int s);
        logic [7:0] b;
        b = 8'(s);
        return {b, ~b} ^ 16'h5a3c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(output bit acc);
        in_valid = 1'b1;
        in_data  = pat(exp_tail);
        @(negedge clk);
        acc = in_ready;
        step();
        in_valid = 1'b0;
        if (acc) exp_tail++;
    endtask

    task automatic ack(int id);
        ack_valid = 1'b1;
        ack_seq   = 8'(id);
        step();
        ack_valid = 1'b0;
    endtask

    task automatic expect_log(int s, bit rep, string req);
        bit ok;
        int act;
        ok  = (lg_rd < lg_n);
        act = ok ? int'(lg_seq[lg_rd]) : -1;
        if (ok) ok = (lg_seq[lg_rd] == 8'(s)) && (lg_dat[lg_rd] == pat(s)) && (lg_rep[lg_rd] == rep);
        check(ok, req, "logged seq/data/replay", act, s % 256);
        if (lg_rd < lg_n) lg_rd++;
    endtask

    task automatic wait_replay(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (out_replay || n > TIMEOUT + 20) break;
            n++;
        end
    endtask

    task automatic wait_quiet(int cyc, string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (out_replay) seen = 1'b1;
        end
        check(!seen, req, "no replay while idle", int'(seen), 0);
        step();
    endtask

    task automatic batch(int k, string req);
        bit acc;
        out_ready = 1'b1;
        for (int i = 0; i < k; i++) begin
            push(acc);
            check(acc, req, "push accepted", int'(acc), 1);
        end
        step();
        step();
        for (int i = 0; i < k; i++) expect_log(exp_tail - k + i, 1'b0, req);
        ack(exp_tail - 1);
    endtask

    task automatic finish_all();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_all();
    end

    initial begin
        bit acc;
        int n;
        int base;

        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_replay && in_ready, "R1", "reset outputs",
              {out_valid, out_replay, in_ready}, 1);
        step();

        // R2/R4/R10: sweep batch sizes, ack all, stay quiet
        for (int k = 1; k <= DEPTH; k++) begin
            batch(k, "R2");
            wait_quiet(TIMEOUT + 4, "R10");
        end

        // R3: fill with no output drain, extra push refused
        out_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            push(acc);
            check(acc, "R3", "fill accepted", int'(acc), 1);
        end
        push(acc);
        check(!acc, "R3", "push when full", int'(acc), 0);
        out_ready = 1'b1;
        repeat (DEPTH + 2) step();
        for (int i = 0; i < DEPTH; i++) expect_log(exp_tail - DEPTH + i, 1'b0, "R3");
        check(lg_rd == lg_n, "R3", "no refused packet sent", lg_n, lg_rd);
        // R5: already released identifier frees nothing
        ack(exp_tail - DEPTH - 1);
        @(negedge clk);
        check(!in_ready, "R5", "stale ack ignored", int'(in_ready), 0);
        step();
        // R4: cumulative ack frees space
        ack(exp_tail - DEPTH + 1);
        @(negedge clk);
        check(in_ready, "R4", "space after ack", int'(in_ready), 1);
        step();
        ack(exp_tail - 1);
        wait_quiet(TIMEOUT + 4, "R4");

        // R6/R7/R8: timeout replays the whole tail
        base = exp_tail;
        for (int i = 0; i < 4; i++) push(acc);
        wait_replay(n);
        check(n == TIMEOUT - 3, "R6", "cycles to replay", n, TIMEOUT - 3);
        check(!in_ready, "R8", "input held in replay", int'(in_ready), 0);
        repeat (6) step();
        for (int i = 0; i < 4; i++) expect_log(base + i, 1'b0, "R2");
        for (int i = 0; i < 4; i++) expect_log(base + i, 1'b1, "R7");
        @(negedge clk);
        check(in_ready && !out_replay, "R8", "input after replay",
              {in_ready, out_replay}, 2);
        step();
        ack(exp_tail - 1);

        // R9: releasing ack restarts the timer
        base = exp_tail;
        for (int i = 0; i < 3; i++) push(acc);
        repeat (10) step();
        ack(base);
        wait_replay(n);
        check(n == TIMEOUT, "R9", "cycles after ack", n, TIMEOUT);
        repeat (5) step();
        for (int i = 0; i < 3; i++) expect_log(base + i, 1'b0, "R2");
        expect_log(base + 1, 1'b1, "R7");
        expect_log(base + 2, 1'b1, "R7");
        ack(exp_tail - 1);

        // R11: ack during replay skips released entries
        base = exp_tail;
        for (int i = 0; i < 4; i++) push(acc);
        step();
        step();
        out_ready = 1'b0;
        wait_replay(n);
        step();
        ack(base + 1);
        out_ready = 1'b1;
        repeat (5) step();
        for (int i = 0; i < 4; i++) expect_log(base + i, 1'b0, "R2");
        expect_log(base + 2, 1'b1, "R11");
        expect_log(base + 3, 1'b1, "R11");
        check(lg_rd == lg_n, "R11", "no released entry resent", lg_n, lg_rd);
        @(negedge clk);
        check(!out_replay, "R11", "replay ended", int'(out_replay), 0);
        step();
        ack(exp_tail - 1);

        // R12: run numbering across the wrap
        while (exp_tail < 262) batch(3, "R12");
        wait_quiet(TIMEOUT + 4, "R12");

        finish_all();
    end
endmodule